// File: doc/BRIEF.md
# Duobinary Three-Level Symbol Slicer

This block turns sampled three-level duobinary line values back into the original bit stream. The stream was precoded and then summed with its own one-bit delay, so the line carries a low, a middle and a high level. Each cycle that a sample arrives, the block places the signed sample against two programmable thresholds. A sample inside the middle band gives a 1 and a sample in either outer region gives a 0. The decision uses no earlier sample. This is the same as reducing the received level (0, 1 or 2) modulo 2, so a single corrupted sample spoils exactly one output bit.

A mode input switches the block to plain two-level slicing against one mid threshold, so that an uncoded link can be read through the same path. For link checking, a reference-bit input can be enabled. A saturating counter then records every decided bit that differs from the reference, and a synchronous clear input zeroes it.

Top module: `duobin_slicer`

## Requirements
- R1: While reset (active low `rst_n`) is asserted, and in the cycle after it is released, `out_valid`, `out_bit` and `err_count` are all 0.
- R2: In three-level mode (`mode_binary` = 0), a valid sample with `thr_lo` < sample < `thr_hi` (signed compare) decodes to 1.
- R3: In three-level mode, a valid sample with sample <= `thr_lo` or sample >= `thr_hi` decodes to 0. A sample equal to either threshold counts as outside the band.
- R4: `out_valid` is `smp_valid` delayed by exactly one clock. `out_bit` presents the decision on the sample accepted in the previous cycle.
- R5: Every decision depends only on its own sample. A single wrongly placed sample in an encoded stream changes only its own output bit.
- R6: In binary mode (`mode_binary` = 1), a valid sample decodes to 1 when sample > `thr_mid` and to 0 otherwise. Equality gives 0.
- R7: On a cycle without a valid sample, `out_bit` keeps its previous value in the next cycle.
- R8: When `ref_en` = 1, each valid sample whose decision differs from `ref_bit` increments `err_count` by one, visible in the same cycle as that sample's `out_bit`.
- R9: `err_count` does not change on cycles where `smp_valid` = 0 or `ref_en` = 0, unless it is cleared.
- R10: `err_count` saturates at its all-ones value and stays there on further mismatches.
- R11: `err_clear` = 1 sets `err_count` to 0 at the next clock edge. The clear takes priority over a mismatch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed received sample |
| mode_binary | input | 1 | 1: two-level slicing, 0: three-level duobinary slicing |
| thr_lo | input | SAMPLE_W | Signed lower edge of middle band |
| thr_hi | input | SAMPLE_W | Signed upper edge of middle band |
| thr_mid | input | SAMPLE_W | Signed threshold for binary mode |
| ref_en | input | 1 | Enables comparison with the reference bit |
| ref_bit | input | 1 | Expected bit for the current sample |
| err_clear | input | 1 | Synchronous clear of the mismatch counter |
| out_valid | output | 1 | Decided bit valid |
| out_bit | output | 1 | Decided bit |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
The hardest case to reach is showing that a decision error does not carry forward. That needs a realistic encoded stream rather than isolated levels. The stimulus precodes a pseudo-random bit sequence, forms the three-level sum with bounded noise, and places one sample in the wrong region. It then checks that every other recovered bit still matches the source bits. Saturation is reached by building the bench with a narrow counter and driving a long run of forced mismatches. The clear is then asserted in the same cycle as a mismatch.

// File: rtl/duobin_pkg.sv
package duobin_pkg;
  typedef enum logic {
    SLICE_TRI = 1'b0,
    SLICE_BIN = 1'b1
  } slice_mode_e;

  localparam int unsigned LEVELS_TRI = 3;
  localparam int unsigned LEVELS_BIN = 2;
endpackage

// File: rtl/duobin_decide.sv
module duobin_decide #(
  parameter int SAMPLE_W = 8
) (
  input  logic                       mode_binary,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] thr_lo,
  input  logic signed [SAMPLE_W-1:0] thr_hi,
  input  logic signed [SAMPLE_W-1:0] thr_mid,
  output logic                       bit_tri,
  output logic                       bit_bin,
  output logic                       decision
);
  import duobin_pkg::*;

  // Middle band is open on both sides: equal to a threshold is outside.
  function automatic logic in_mid_band(
    input logic signed [SAMPLE_W-1:0] s,
    input logic signed [SAMPLE_W-1:0] lo,
    input logic signed [SAMPLE_W-1:0] hi
  );
    return (s > lo) && (s < hi);
  endfunction

  function automatic logic above_mid(
    input logic signed [SAMPLE_W-1:0] s,
    input logic signed [SAMPLE_W-1:0] mid
  );
    return s > mid;
  endfunction

  slice_mode_e mode_sel;

  always_comb begin
    mode_sel = slice_mode_e'(mode_binary);
    bit_tri  = in_mid_band(sample, thr_lo, thr_hi);
    bit_bin  = above_mid(sample, thr_mid);
    case (mode_sel)
      SLICE_BIN: decision = bit_bin;
      default:   decision = bit_tri;
    endcase
  end
endmodule

// File: rtl/duobin_out_stage.sv
module duobin_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic q_valid,
  output logic q_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_bit   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) q_bit <= in_bit;
    end
  end
endmodule

// File: rtl/duobin_err_cnt.sv
module duobin_err_cnt #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  function automatic logic [ERR_W-1:0] sat_step(input logic [ERR_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (inc)    count <= sat_step(count);
  end
endmodule

// File: rtl/duobin_slicer.sv
module duobin_slicer #(
  parameter int SAMPLE_W = 8,
  parameter int ERR_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       mode_binary,
  input  logic signed [SAMPLE_W-1:0] thr_lo,
  input  logic signed [SAMPLE_W-1:0] thr_hi,
  input  logic signed [SAMPLE_W-1:0] thr_mid,
  input  logic                       ref_en,
  input  logic                       ref_bit,
  input  logic                       err_clear,
  output logic                       out_valid,
  output logic                       out_bit,
  output logic [ERR_W-1:0]           err_count
);
  // Named internal events, used by the bound checker.
  logic dec_tri;
  logic dec_bin;
  logic dec_bit;
  logic mismatch_evt;
  logic err_inc;

  duobin_decide #(.SAMPLE_W(SAMPLE_W)) u_decide (
    .mode_binary (mode_binary),
    .sample      (smp_data),
    .thr_lo      (thr_lo),
    .thr_hi      (thr_hi),
    .thr_mid     (thr_mid),
    .bit_tri     (dec_tri),
    .bit_bin     (dec_bin),
    .decision    (dec_bit)
  );

  assign mismatch_evt = dec_bit ^ ref_bit;
  assign err_inc      = smp_valid & ref_en & mismatch_evt;

  duobin_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_bit   (dec_bit),
    .q_valid  (out_valid),
    .q_bit    (out_bit)
  );

  duobin_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clear),
    .inc   (err_inc),
    .count (err_count)
  );
endmodule

// File: rtl/duobin_slicer_chk.sv
module duobin_slicer_chk #(
  parameter int SAMPLE_W = 8,
  parameter int ERR_W    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_valid,
  input logic signed [SAMPLE_W-1:0] smp_data,
  input logic                       mode_binary,
  input logic signed [SAMPLE_W-1:0] thr_lo,
  input logic signed [SAMPLE_W-1:0] thr_hi,
  input logic signed [SAMPLE_W-1:0] thr_mid,
  input logic                       ref_en,
  input logic                       err_clear,
  input logic                       err_inc,
  input logic                       out_valid,
  input logic                       out_bit,
  input logic [ERR_W-1:0]           err_count
);
  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  assert_band_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mode_binary && smp_data > thr_lo && smp_data < thr_hi) |=> out_bit);

  assert_outer_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mode_binary && (smp_data <= thr_lo || smp_data >= thr_hi)) |=> !out_bit);

  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);

  assert_binary_slice_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_binary) |=> (out_bit == $past(smp_data > thr_mid)));

  assert_hold_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(out_bit));

  assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!smp_valid || !ref_en) && !err_clear) |=> $stable(err_count));

  assert_inc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_inc && !err_clear && err_count != CNT_MAX) |=> (err_count == $past(err_count) + 1'b1));

  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !err_clear) |=> (err_count == CNT_MAX));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (err_count == '0));
endmodule

bind duobin_slicer duobin_slicer_chk #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_data    (smp_data),
  .mode_binary (mode_binary),
  .thr_lo      (thr_lo),
  .thr_hi      (thr_hi),
  .thr_mid     (thr_mid),
  .ref_en      (ref_en),
  .err_clear   (err_clear),
  .err_inc     (err_inc),
  .out_valid   (out_valid),
  .out_bit     (out_bit),
  .err_count   (err_count)
);

// File: tb/sim_duobin_slicer.sv
`timescale 1ns/1ps
module sim_duobin_slicer;
  localparam int SW = 8;
  localparam int EW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic mode_binary = 1'b0;
  logic signed [SW-1:0] thr_lo = -8'sd32;
  logic signed [SW-1:0] thr_hi = 8'sd32;
  logic signed [SW-1:0] thr_mid = 8'sd0;
  logic ref_en = 1'b0;
  logic ref_bit = 1'b0;
  logic err_clear = 1'b0;
  logic out_valid;
  logic out_bit;
  logic [EW-1:0] err_count;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural model state
  int exp_valid = 0;
  int exp_bit = 0;
  int exp_cnt = 0;
  string cnt_tag = "R9";

  always #2.5 clk = ~clk;

  duobin_slicer #(.SAMPLE_W(SW), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .mode_binary(mode_binary), .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_mid(thr_mid),
    .ref_en(ref_en), .ref_bit(ref_bit), .err_clear(err_clear),
    .out_valid(out_valid), .out_bit(out_bit), .err_count(err_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_decide(input int d);
    if (mode_binary) return (d > int'(thr_mid)) ? 1 : 0;
    return (d > int'(thr_lo) && d < int'(thr_hi)) ? 1 : 0;
  endfunction

  // One clock: apply inputs, advance model, compare just after the edge.
  task automatic cyc(input bit v, input int d, input bit rb, input string btag);
    int db;
    smp_valid = v;
    smp_data  = d[SW-1:0];
    ref_bit   = rb;
    db = model_decide(d);
    @(posedge clk);
    if (err_clear) exp_cnt = 0;
    else if (v && ref_en && db != int'(rb) && exp_cnt < CMAX) exp_cnt++;
    exp_valid = v ? 1 : 0;
    if (v) exp_bit = db;
    #1;
    check("R4", int'(out_valid), exp_valid);
    check(btag, int'(out_bit), exp_bit);
    check(cnt_tag, int'(err_count), exp_cnt);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    int pprev;
    int corrupt_at;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_bit), 0);
    check("R1", int'(err_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'(err_count), 0);
    @(negedge clk);

    // R2 / R3: fixed levels and threshold edges
    cyc(1, -64, 0, "R3");
    cyc(1, 0,   0, "R2");
    cyc(1, 64,  0, "R3");
    cyc(1, -31, 0, "R2");
    cyc(1, -32, 0, "R3");
    cyc(1, 31,  0, "R2");
    cyc(1, 32,  0, "R3");
    cyc(1, 127, 0, "R3");
    cyc(1, 5,   0, "R2");
    cyc(1, -128, 0, "R3");

    // R7: gaps hold the last bit (last valid was 0, then set 1 and gap)
    cyc(1, 10, 0, "R2");
    cyc(0, 100, 0, "R7");
    cyc(0, -100, 0, "R7");
    cyc(1, 90, 0, "R3");
    cyc(0, 0, 0, "R7");

    // R5: precoded duobinary stream with noise, one corrupted sample
    seed = 32'h1234_5678;
    pprev = 0;
    corrupt_at = 17;
    for (int i = 0; i < 48; i++) begin
      int b, p, lvl, noise, s;
      seed  = seed * 32'd1103515245 + 32'd12345;
      b     = int'(seed[16]);
      noise = int'(seed[13:8] % 6'd41) - 20;
      p     = b ^ pprev;
      lvl   = p + pprev;
      s     = (lvl - 1) * 64 + noise;
      pprev = p;
      if (i == corrupt_at) s = (b == 1) ? 64 : 0;
      cyc(1, s, 0, "R2");
      if (i != corrupt_at) check("R5", int'(out_bit), b);
      else                 check("R5", int'(out_bit), 1 - b);
    end

    // R6: binary mode
    mode_binary = 1'b1;
    thr_mid = 8'sd0;
    cyc(1, 1,   0, "R6");
    cyc(1, 0,   0, "R6");
    cyc(1, 100, 0, "R6");
    cyc(1, -5,  0, "R6");
    thr_mid = -8'sd20;
    cyc(1, -19, 0, "R6");
    cyc(1, -20, 0, "R6");
    cyc(1, 60,  0, "R6");
    mode_binary = 1'b0;
    cyc(1, 60,  0, "R3");

    // R8: mismatches counted
    ref_en = 1'b1;
    cnt_tag = "R8";
    cyc(1, 0,   1, "R2");   // match
    cyc(1, 0,   0, "R2");   // mismatch -> 1
    cyc(1, 64,  1, "R3");   // mismatch -> 2
    cyc(1, 64,  0, "R3");   // match
    cyc(1, -64, 1, "R3");   // mismatch -> 3

    // R9: no count when disabled or invalid
    cnt_tag = "R9";
    cyc(0, 0, 0, "R7");
    ref_en = 1'b0;
    cyc(1, 0, 0, "R2");
    cyc(1, 64, 1, "R3");
    ref_en = 1'b1;

    // R10: saturation
    cnt_tag = "R10";
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, "R2");
    check("R10", int'(err_count), CMAX);

    // R11: clear, with a simultaneous mismatch
    cnt_tag = "R11";
    err_clear = 1'b1;
    cyc(1, 0, 0, "R2");
    err_clear = 1'b0;
    check("R11", int'(err_count), 0);
    cyc(1, 0, 0, "R2");
    err_clear = 1'b1;
    cyc(0, 0, 0, "R7");
    err_clear = 1'b0;
    cyc(1, 0, 1, "R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule